// File: doc/BRIEF.md
# Split-Bus Transaction Timing Recorder

This block is a passive probe placed beside a split-transaction bus port. The port has a request path and a return path. Each path carries a valid, a grant and a last-beat flag. The probe never drives the bus. It watches the handshakes, finds where each request packet opens and closes, and finds where each return packet opens and closes. From these events it derives three cycle counts for every transaction:

- the duration of the request packet;
- the quiet gap before the packet, measured from the close of the previous request packet;
- the round-trip time from the opening of the request to the close of its response.

At the close of the response it packs these counts with the address and opcode of the request into one record word. It stores that word in an internal record FIFO. The probe keeps no absolute time: the intervals alone let offline software rebuild the timeline.

Records leave through a dump stream with valid/ready handshaking. `dump_valid` is high whenever at least one record is stored. A record transfers on a cycle where both `dump_valid` and `dump_ready` are high. While `dump_ready` is low, the head record and `dump_valid` stay unchanged. Traffic recording goes on during back-pressure until the FIFO is full. The block also reports the fill level and a sticky overflow flag.

Responses are assumed to return in request order. Each response is assumed to open after its request has closed. At most `PEND_DEPTH` requests may be outstanding at once. `PEND_DEPTH` and `REC_DEPTH` are powers of two, each at least 2.

Top module: `txn_recorder`

## Requirements
- R1: A request packet opens on a cycle with `rq_valid` and `rq_grant` both high while no request packet is open. It closes on a cycle with `rq_valid`, `rq_grant` and `rq_last` all high, which may be the opening cycle. Cycles with the grant low do not open or close a packet.
- R2: The duration field equals the number of clock edges from the opening cycle to the closing cycle of the same request packet. It is 0 for a single-beat packet and saturates at 2^DUR_W-1.
- R3: The gap field equals the number of cycles from the previous request close to this request's opening. It saturates at 2^GAP_W-1 and is 0 for the first request after reset.
- R4: The round-trip field equals the number of cycles from a request's opening to the close of its response. It saturates at 2^RTT_W-1. Responses pair with requests in request order.
- R5: Address and opcode are taken from the opening cycle of the request. Values presented on later beats are ignored.
- R6: Each response close that has an outstanding request writes exactly one record. The record is {dur, gap, rtt, addr, opc}, with dur in the most significant bits and opc in the least significant bits. A response opening alone writes nothing.
- R7: A response close with no outstanding request writes no record.
- R8: `dump_valid` is high when the FIFO holds a record. `dump_data` presents the oldest record. A record is removed on `dump_valid && dump_ready`. While `dump_ready` is low, `dump_data` holds.
- R9: `rec_fill` equals the number of stored records and never exceeds `REC_DEPTH`.
- R10: A record that arrives while the FIFO holds `REC_DEPTH` records is dropped and `overflow` is set. `overflow` stays set until reset.
- R11: After reset, `rec_fill` is 0, `dump_valid` is 0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 1 | Request path valid (observed) |
| rq_grant | input | 1 | Request path grant (observed) |
| rq_last | input | 1 | Request last beat (observed) |
| rq_addr | input | ADDR_W | Request address (observed) |
| rq_opc | input | OPC_W | Request opcode (observed) |
| rs_valid | input | 1 | Return path valid (observed) |
| rs_grant | input | 1 | Return path grant (observed) |
| rs_last | input | 1 | Return last beat (observed) |
| dump_ready | input | 1 | Dump stream ready |
| dump_valid | output | 1 | Dump stream valid |
| dump_data | output | REC_W | Oldest stored record |
| rec_fill | output | FILL_W | Stored record count |
| overflow | output | 1 | Sticky record drop flag |

## Verification
The bench runs several traffic patterns, and each one exposes a different class of error:

- Single-beat packets against multi-beat packets with grant stalls separate a wrong duration count from a wrong open/close detection.
- Packets whose address and opcode change after the first beat show whether capture happens at the opening cycle.
- Three overlapping requests with back-to-back responses test in-order pairing and the per-request round-trip counting.
- Very long packets, gaps and latencies drive every field into saturation.

A lone response tests that orphans are ignored. Seventeen transactions into a sixteen-deep FIFO test drop and sticky overflow. Every dump runs under periodic back-pressure, so any movement of the held record shows up.

// File: rtl/txrec_pkg.sv
package txrec_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_OPEN = 1'b1
  } phase_e;

  function automatic int rec_width(input int dur_w, input int gap_w,
                                   input int rtt_w, input int addr_w,
                                   input int opc_w);
    return dur_w + gap_w + rtt_w + addr_w + opc_w;
  endfunction

endpackage

// File: rtl/txrec_phase.sv
module txrec_phase
  import txrec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic grant,
  input  logic last,
  output logic opens,
  output logic closes
);
  phase_e state;
  logic   beat;

  assign beat   = valid && grant;
  assign opens  = beat && (state == PH_IDLE);
  assign closes = beat && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PH_IDLE;
    end else if (beat) begin
      state <= last ? PH_IDLE : PH_OPEN;
    end
  end
endmodule

// File: rtl/txrec_timer.sv
module txrec_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (restart) begin
      count <= W'(1);
    end else if (count != '1) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/txrec_pending.sv
module txrec_pending #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int OPC_W  = 4,
  parameter int DUR_W  = 6,
  parameter int GAP_W  = 6,
  parameter int RTT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [OPC_W-1:0]  push_opc,
  input  logic [GAP_W-1:0]  push_gap,
  input  logic              set_dur,
  input  logic [DUR_W-1:0]  dur_val,
  input  logic              pop,
  output logic              has_head,
  output logic [ADDR_W-1:0] head_addr,
  output logic [OPC_W-1:0]  head_opc,
  output logic [GAP_W-1:0]  head_gap,
  output logic [DUR_W-1:0]  head_dur,
  output logic [RTT_W-1:0]  head_rtt
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0]     wptr, rptr, last_ptr;
  logic [PW:0]       count;
  logic              push_ok, pop_ok;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [OPC_W-1:0]  opc_q  [DEPTH];
  logic [GAP_W-1:0]  gap_q  [DEPTH];
  logic [DUR_W-1:0]  dur_q  [DEPTH];
  logic [RTT_W-1:0]  age_w  [DEPTH];

  assign push_ok  = push && (count < (PW+1)'(DEPTH));
  assign has_head = (count != '0);
  assign pop_ok   = pop && has_head;

  // one saturating age counter per slot, restarted when the slot is filled
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [RTT_W-1:0] age;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age <= '0;
      end else if (push_ok && (wptr == PW'(g))) begin
        age <= RTT_W'(1);
      end else if (age != '1) begin
        age <= age + 1'b1;
      end
    end
    assign age_w[g] = age;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      last_ptr <= '0;
      count    <= '0;
    end else begin
      if (push_ok) begin
        wptr     <= wptr + 1'b1;
        last_ptr <= wptr;
      end
      if (pop_ok) rptr <= rptr + 1'b1;
      count <= count + (PW+1)'(push_ok) - (PW+1)'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      addr_q[wptr] <= push_addr;
      opc_q[wptr]  <= push_opc;
      gap_q[wptr]  <= push_gap;
      dur_q[wptr]  <= set_dur ? dur_val : '0;
    end
    if (set_dur && !push_ok) begin
      dur_q[last_ptr] <= dur_val;
    end
  end

  assign head_addr = addr_q[rptr];
  assign head_opc  = opc_q[rptr];
  assign head_gap  = gap_q[rptr];
  assign head_dur  = dur_q[rptr];
  assign head_rtt  = age_w[rptr];
endmodule

// File: rtl/txrec_store.sv
module txrec_store #(
  parameter int DEPTH = 16,
  parameter int W     = 40,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic [FW-1:0] fill,
  output logic          overflow
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          full, accept, take;

  assign full     = (fill == FW'(DEPTH));
  assign accept   = wr && !full;
  assign rd_valid = (fill != '0);
  assign take     = rd_valid && rd_ready;
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wptr <= wptr + 1'b1;
      if (take)   rptr <= rptr + 1'b1;
      fill <= fill + FW'(accept) - FW'(take);
      if (wr && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= wr_data;
  end
endmodule

// File: rtl/txn_recorder.sv
module txn_recorder #(
  parameter int ADDR_W     = 16,
  parameter int OPC_W      = 4,
  parameter int DUR_W      = 6,
  parameter int GAP_W      = 6,
  parameter int RTT_W      = 8,
  parameter int PEND_DEPTH = 4,
  parameter int REC_DEPTH  = 16,
  localparam int REC_W  = txrec_pkg::rec_width(DUR_W, GAP_W, RTT_W, ADDR_W, OPC_W),
  localparam int FILL_W = $clog2(REC_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_valid,
  input  logic              rq_grant,
  input  logic              rq_last,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [OPC_W-1:0]  rq_opc,
  input  logic              rs_valid,
  input  logic              rs_grant,
  input  logic              rs_last,
  input  logic              dump_ready,
  output logic              dump_valid,
  output logic [REC_W-1:0]  dump_data,
  output logic [FILL_W-1:0] rec_fill,
  output logic              overflow
);
  logic              req_open_ev, req_close_ev, ret_open_ev, ret_close_ev;
  logic [DUR_W-1:0]  dur_cnt, dur_val;
  logic [GAP_W-1:0]  gap_cnt, gap_val;
  logic              gap_valid;
  logic              has_head;
  logic [ADDR_W-1:0] head_addr;
  logic [OPC_W-1:0]  head_opc;
  logic [GAP_W-1:0]  head_gap;
  logic [DUR_W-1:0]  head_dur;
  logic [RTT_W-1:0]  head_rtt;
  logic              rec_wr;
  logic [REC_W-1:0]  rec_word;

  txrec_phase u_req_phase (
    .clk(clk), .rst_n(rst_n), .valid(rq_valid), .grant(rq_grant), .last(rq_last),
    .opens(req_open_ev), .closes(req_close_ev)
  );

  txrec_phase u_ret_phase (
    .clk(clk), .rst_n(rst_n), .valid(rs_valid), .grant(rs_grant), .last(rs_last),
    .opens(ret_open_ev), .closes(ret_close_ev)
  );

  txrec_timer #(.W(DUR_W)) u_dur_timer (
    .clk(clk), .rst_n(rst_n), .restart(req_open_ev), .count(dur_cnt)
  );

  txrec_timer #(.W(GAP_W)) u_gap_timer (
    .clk(clk), .rst_n(rst_n), .restart(req_close_ev), .count(gap_cnt)
  );

  // no gap is known until a first request has closed
  always_ff @(posedge clk) begin
    if (!rst_n)            gap_valid <= 1'b0;
    else if (req_close_ev) gap_valid <= 1'b1;
  end

  assign dur_val = req_open_ev ? '0 : dur_cnt;
  assign gap_val = gap_valid ? gap_cnt : '0;

  txrec_pending #(
    .DEPTH(PEND_DEPTH), .ADDR_W(ADDR_W), .OPC_W(OPC_W),
    .DUR_W(DUR_W), .GAP_W(GAP_W), .RTT_W(RTT_W)
  ) u_pending (
    .clk(clk), .rst_n(rst_n),
    .push(req_open_ev), .push_addr(rq_addr), .push_opc(rq_opc), .push_gap(gap_val),
    .set_dur(req_close_ev), .dur_val(dur_val),
    .pop(ret_close_ev),
    .has_head(has_head), .head_addr(head_addr), .head_opc(head_opc),
    .head_gap(head_gap), .head_dur(head_dur), .head_rtt(head_rtt)
  );

  assign rec_wr   = ret_close_ev && has_head;
  assign rec_word = {head_dur, head_gap, head_rtt, head_addr, head_opc};

  txrec_store #(.DEPTH(REC_DEPTH), .W(REC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr(rec_wr), .wr_data(rec_word),
    .rd_ready(dump_ready), .rd_valid(dump_valid), .rd_data(dump_data),
    .fill(rec_fill), .overflow(overflow)
  );
endmodule

// File: rtl/txn_recorder_chk.sv
module txn_recorder_chk #(
  parameter int REC_DEPTH = 16,
  parameter int REC_W     = 40,
  parameter int FILL_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_open_ev,
  input logic              req_close_ev,
  input logic              ret_open_ev,
  input logic              ret_close_ev,
  input logic              dump_valid,
  input logic              dump_ready,
  input logic [REC_W-1:0]  dump_data,
  input logic [FILL_W-1:0] rec_fill,
  input logic              overflow
);
  logic req_seen_open, ret_seen_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_seen_open <= 1'b0;
      ret_seen_open <= 1'b0;
    end else begin
      if (req_close_ev)     req_seen_open <= 1'b0;
      else if (req_open_ev) req_seen_open <= 1'b1;
      if (ret_close_ev)     ret_seen_open <= 1'b0;
      else if (ret_open_ev) ret_seen_open <= 1'b1;
    end
  end

  p_close_after_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_close_ev && !req_open_ev) |-> req_seen_open);

  p_ret_close_after_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_close_ev && !ret_open_ev) |-> ret_seen_open);

  p_hold_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid && !dump_ready) |=> (dump_valid && $stable(dump_data)));

  p_fill_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_close_ev |=> (rec_fill <= $past(rec_fill)));

  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_overflow_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(rec_fill) == FILL_W'(REC_DEPTH)));

  always @(posedge clk) begin
    if (rst_n) begin
      p_fill_bound_r9: assert (rec_fill <= FILL_W'(REC_DEPTH));
    end
  end
endmodule

bind txn_recorder txn_recorder_chk #(
  .REC_DEPTH(REC_DEPTH), .REC_W(REC_W), .FILL_W(FILL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_open_ev(req_open_ev), .req_close_ev(req_close_ev),
  .ret_open_ev(ret_open_ev), .ret_close_ev(ret_close_ev),
  .dump_valid(dump_valid), .dump_ready(dump_ready), .dump_data(dump_data),
  .rec_fill(rec_fill), .overflow(overflow)
);

// File: tb/txn_recorder_test.sv
module txn_recorder_test;
  localparam int AW = 16, OW = 4, DW = 6, GW = 6, TW = 8, PD = 4, RD = 16;
  localparam int RW = DW + GW + TW + AW + OW;
  localparam int FW = $clog2(RD + 1);
  localparam int OPC_LO = 0, ADDR_LO = OW, RTT_LO = OW + AW;
  localparam int GAP_LO = RTT_LO + TW, DUR_LO = GAP_LO + GW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rq_valid = 0, rq_grant = 0, rq_last = 0;
  logic [AW-1:0] rq_addr = '0;
  logic [OW-1:0] rq_opc = '0;
  logic rs_valid = 0, rs_grant = 0, rs_last = 0;
  logic dump_ready = 0;
  logic dump_valid;
  logic [RW-1:0] dump_data;
  logic [FW-1:0] rec_fill;
  logic overflow;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  txn_recorder #(
    .ADDR_W(AW), .OPC_W(OW), .DUR_W(DW), .GAP_W(GW), .RTT_W(TW),
    .PEND_DEPTH(PD), .REC_DEPTH(RD)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_grant(rq_grant), .rq_last(rq_last),
    .rq_addr(rq_addr), .rq_opc(rq_opc),
    .rs_valid(rs_valid), .rs_grant(rs_grant), .rs_last(rs_last),
    .dump_ready(dump_ready), .dump_valid(dump_valid), .dump_data(dump_data),
    .rec_fill(rec_fill), .overflow(overflow)
  );

  // ---------------- reference model from the requirements ----------------
  int cyc = 0;
  bit m_req_open = 0, m_ret_open = 0, m_seen_close = 0;
  int m_last_close = 0;
  int m_ts[$], m_gap[$], m_dur[$];
  logic [AW-1:0] m_addr[$];
  logic [OW-1:0] m_opc[$];
  logic [RW-1:0] exp_q[$];
  bit exp_ovf = 0;

  function automatic int sat(input int v, input int w);
    int mx = (1 << w) - 1;
    return (v > mx) ? mx : v;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit ts, te, tre;
      cyc++;
      ts  = rq_valid && rq_grant && !m_req_open;
      te  = rq_valid && rq_grant && rq_last;
      tre = rs_valid && rs_grant && rs_last;
      if (tre && m_ts.size() != 0) begin
        logic [RW-1:0] w;
        w = {DW'(m_dur[0]), GW'(m_gap[0]), TW'(sat(cyc - m_ts[0], TW)), m_addr[0], m_opc[0]};
        void'(m_ts.pop_front()); void'(m_gap.pop_front()); void'(m_dur.pop_front());
        void'(m_addr.pop_front()); void'(m_opc.pop_front());
        if (exp_q.size() < RD) exp_q.push_back(w);
        else exp_ovf = 1;
      end
      if (ts) begin
        m_ts.push_back(cyc);
        m_gap.push_back(m_seen_close ? sat(cyc - m_last_close, GW) : 0);
        m_dur.push_back(0);
        m_addr.push_back(rq_addr);
        m_opc.push_back(rq_opc);
      end
      if (te) begin
        m_dur[m_dur.size()-1] = sat(cyc - m_ts[m_ts.size()-1], DW);
        m_last_close = cyc;
        m_seen_close = 1;
      end
      if (rq_valid && rq_grant) m_req_open = !rq_last;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic do_req(input logic [AW-1:0] a, input logic [OW-1:0] o,
                        input int beats, input bit stall);
    for (int b = 0; b < beats; b++) begin
      if (stall && b == 1) begin
        rq_valid = 1; rq_grant = 0; rq_last = 0;
        @(negedge clk);
      end
      rq_valid = 1; rq_grant = 1; rq_last = (b == beats - 1);
      rq_addr = a + AW'(b); rq_opc = o ^ OW'(b);
      @(negedge clk);
    end
    rq_valid = 0; rq_grant = 0; rq_last = 0;
  endtask

  task automatic do_ret(input int beats, input bit stall);
    for (int b = 0; b < beats; b++) begin
      if (stall && b == 1) begin
        rs_valid = 1; rs_grant = 0; rs_last = 0;
        @(negedge clk);
      end
      rs_valid = 1; rs_grant = 1; rs_last = (b == beats - 1);
      @(negedge clk);
    end
    rs_valid = 0; rs_grant = 0; rs_last = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dump_all(input int stall_mod);
    int k = 0;
    while (dump_valid) begin
      logic [RW-1:0] e, d;
      e = (exp_q.size() != 0) ? exp_q[0] : '0;
      d = dump_data;
      chk(exp_q.size() != 0, "R6 record count", 1, exp_q.size());
      chk(d[DUR_LO+:DW] == e[DUR_LO+:DW], "R2 dur", d[DUR_LO+:DW], e[DUR_LO+:DW]);
      chk(d[GAP_LO+:GW] == e[GAP_LO+:GW], "R3 gap", d[GAP_LO+:GW], e[GAP_LO+:GW]);
      chk(d[RTT_LO+:TW] == e[RTT_LO+:TW], "R4 rtt", d[RTT_LO+:TW], e[RTT_LO+:TW]);
      chk(d[ADDR_LO+:AW] == e[ADDR_LO+:AW] && d[OPC_LO+:OW] == e[OPC_LO+:OW],
          "R5 addr/opc", d[OW+AW-1:0], e[OW+AW-1:0]);
      if (stall_mod != 0 && k % stall_mod == 0) begin
        dump_ready = 0;
        @(negedge clk);
        chk(dump_valid && dump_data == d, "R8 held under back-pressure", dump_data, d);
      end
      dump_ready = 1;
      @(negedge clk);
      dump_ready = 0;
      if (exp_q.size() != 0) void'(exp_q.pop_front());
      k++;
    end
    chk(exp_q.size() == 0, "R8 drained all records", 0, exp_q.size());
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rec_fill == 0 && !dump_valid && !overflow, "R11 reset state",
        {rec_fill, dump_valid, overflow}, 0);

    // varied patterns: single beat, stalled multi-beat, overlapping requests
    idle(3);
    do_req(16'h1110, 4'h1, 1, 0);     // R1 single-beat open and close
    idle(2); do_ret(1, 0);
    idle(4);
    do_req(16'h2220, 4'h2, 3, 1);     // R1 R5 grant stall, later-beat addr ignored
    idle(3); do_ret(2, 1);
    idle(2);
    fork
      begin
        do_req(16'h3330, 4'h3, 1, 0);
        do_req(16'h4440, 4'h4, 2, 0);
        idle(1);
        do_req(16'h5550, 4'h5, 1, 0);
      end
      begin
        idle(7);
        do_ret(1, 0); do_ret(2, 0); do_ret(1, 1);   // R4 in-order pairing
      end
    join
    idle(2);
    chk(rec_fill == FW'(exp_q.size()), "R9 fill after patterns", rec_fill, exp_q.size());
    chk(exp_q.size() == 5, "R6 one record per response", exp_q.size(), 5);
    dump_all(2);

    // orphan response and lone response opening
    rs_valid = 1; rs_grant = 1; rs_last = 0; @(negedge clk);
    chk(rec_fill == 0, "R6 response opening writes nothing", rec_fill, 0);
    rs_last = 1; @(negedge clk);
    rs_valid = 0; rs_grant = 0; rs_last = 0;
    idle(2);
    chk(rec_fill == 0 && !dump_valid, "R7 orphan response ignored", rec_fill, 0);

    // saturation of every interval
    do_req(16'h6660, 4'h6, 70, 0);    // R2 saturates
    idle(300); do_ret(1, 0);          // R4 saturates
    idle(80);
    do_req(16'h7770, 4'h7, 1, 0);     // R3 saturates
    idle(1); do_ret(1, 0);
    idle(2);
    chk(rec_fill == 2, "R9 fill after saturation", rec_fill, 2);
    dump_all(3);

    // overflow
    for (int i = 0; i < RD + 1; i++) begin
      do_req(AW'(16'h8000 + i * 16), OW'(i), 1 + (i % 2), 0);
      idle(i % 3); do_ret(1, 0);
    end
    idle(2);
    chk(rec_fill == FW'(RD), "R9 fill saturates at depth", rec_fill, RD);
    chk(overflow == 1 && exp_ovf, "R10 overflow raised", overflow, 1);
    dump_all(4);
    chk(overflow == 1, "R10 overflow sticky after drain", overflow, 1);
    chk(rec_fill == 0 && !dump_valid, "R8 empty after drain", rec_fill, 0);
    finish_up();
  end
endmodule